// File: doc/BRIEF.md
# Serial Command Packet Engine

This block is the host side of a one-wire serial link to a device that owns a small memory. When a request arrives, it sends an 11-bit header made of a 2-bit operation code and a 9-bit word address. It then drives the line low and waits for the device to signal an acknowledge. After that it either sends or receives a data phase. The data phase is one 32-bit word or a 512-bit block, depending on the code. When the last data bit has moved, the block raises a one-cycle done pulse.

Every serial bit advances only on a clock cycle in which the bit-enable input is high. Bits go most significant first. Requests are taken only while the engine is idle. For reads, the received data stays on a parallel output until the next read finishes.

Top module: `serial_pkt_engine`

## Requirements
- R1: After reset `busy`, `done` and `ser_out` are low and `rd_data` is all zeros.
- R2: The header is 11 bits. The 2-bit code goes first, then the 9-bit word address, each most significant bit first. One bit goes out per cycle with `bit_en` high. While `bit_en` is low, `ser_out` holds its value.
- R3: Operation codes: 2'b11 reads one word, 2'b10 writes one word, 2'b01 reads a 512-bit block, 2'b00 writes a 512-bit block.
- R4: After the header, `ser_out` is low. The engine waits for an acknowledge, which is `ser_in` high on a cycle with `bit_en` high. There is no limit on the wait, and `busy` stays high throughout.
- R5: For a write, the data phase starts on the `bit_en` tick after the acknowledge. It sends `req_wdata[31:0]` (word) or `req_wdata[511:0]` (block), most significant bit first.
- R6: For a read, 32 or 512 bits of `ser_in` are sampled on `bit_en` ticks, and the first bit is the most significant. A word result appears in `rd_data[31:0]` with the upper bits zero. A block result fills `rd_data[511:0]`.
- R7: `done` is high for exactly one cycle: the cycle after the clock edge that moved the last data bit.
- R8: `busy` goes high the cycle after a request is accepted. It stays high through the `done` cycle and drops on the cycle after it.
- R9: While `busy` is high, `req_valid` and the request fields are ignored. The transfer in progress is not changed, and no new transfer starts once it ends.
- R10: `rd_data` changes only when a read completes. Writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Serial bit tick |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_cmd | input | 2 | Operation code |
| req_addr | input | 9 | Word address (byte address bits 10..2) |
| req_wdata | input | 512 | Write data; a word uses bits 31..0 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 512 | Last read result |
| ser_out | output | 1 | Serial line to the device |
| ser_in | input | 1 | Serial line from the device; idles low |

## Verification
`busy` is due one cycle after the accepting edge. Each header or write bit is on `ser_out` from the edge that consumed the previous tick until the edge of its own tick. `done` and a new `rd_data` are due one cycle after the edge of the last data tick, and `busy` falls one cycle after that. The bench drives inputs on the falling edge and samples outputs 1 ns later. It compares every clock against its own tick-counting model, so each expected value is checked in exactly the cycle it is due, including the stall cycles where `bit_en` is low.

// File: rtl/spe_pkg.sv
package spe_pkg;

  typedef enum logic [1:0] {
    CMD_BLK_WR  = 2'b00,
    CMD_BLK_RD  = 2'b01,
    CMD_WORD_WR = 2'b10,
    CMD_WORD_RD = 2'b11
  } spe_cmd_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_HDR, PH_ACK, PH_TX, PH_RX, PH_FIN
  } spe_phase_e;

  function automatic logic spe_is_read(input logic [1:0] cmd);
    return cmd[0];
  endfunction

  function automatic logic spe_is_block(input logic [1:0] cmd);
    return ~cmd[1];
  endfunction

  function automatic int spe_data_bits(input logic [1:0] cmd, input int word_bits,
                                       input int block_bits);
    return spe_is_block(cmd) ? block_bits : word_bits;
  endfunction

endpackage

// File: rtl/spe_hdr_shift.sv
module spe_hdr_shift #(
  parameter int HDR_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [HDR_W-1:0] load_val,
  input  logic             shift,
  output logic             msb
);
  logic [HDR_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[HDR_W-2:0], 1'b0};
  end

  assign msb = sr[HDR_W-1];
endmodule

// File: rtl/spe_data_shift.sv
module spe_data_shift #(
  parameter int DW = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          shift,
  input  logic          sin,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[DW-2:0], sin};
  end
endmodule

// File: rtl/spe_ctrl.sv
module spe_ctrl
  import spe_pkg::*;
#(
  parameter int HDR_W      = 11,
  parameter int WORD_BITS  = 32,
  parameter int BLOCK_BITS = 512,
  parameter int CNT_W      = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       req_valid,
  input  logic [1:0] req_cmd,
  input  logic       ser_in,
  output spe_phase_e phase,
  output logic       accept,
  output logic       hdr_shift,
  output logic       hdr_done,
  output logic       ack_seen,
  output logic       dat_shift,
  output logic       data_done,
  output logic       busy,
  output logic       done
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_q;
  logic [1:0]       cmd_q;

  always_comb begin
    accept    = (phase == PH_IDLE) && req_valid;
    hdr_shift = (phase == PH_HDR) && bit_en;
    hdr_done  = hdr_shift && (cnt == CNT_W'(HDR_W - 1));
    ack_seen  = (phase == PH_ACK) && bit_en && ser_in;
    dat_shift = ((phase == PH_TX) || (phase == PH_RX)) && bit_en;
    data_done = dat_shift && (cnt == last_q);
    busy      = (phase != PH_IDLE);
    done      = (phase == PH_FIN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      last_q <= '0;
      cmd_q  <= 2'b00;
    end else begin
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase  <= PH_HDR;
          cnt    <= '0;
          cmd_q  <= req_cmd;
          last_q <= CNT_W'(spe_data_bits(req_cmd, WORD_BITS, BLOCK_BITS) - 1);
        end
        PH_HDR: if (hdr_shift) begin
          if (hdr_done) begin
            phase <= PH_ACK;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ACK: if (ack_seen) phase <= spe_is_read(cmd_q) ? PH_RX : PH_TX;
        PH_TX, PH_RX: if (dat_shift) begin
          if (data_done) phase <= PH_FIN;
          else           cnt   <= cnt + 1'b1;
        end
        PH_FIN: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_pkt_engine.sv
module serial_pkt_engine
  import spe_pkg::*;
#(
  parameter int CMD_W      = 2,
  parameter int AW         = 9,
  parameter int WORD_BITS  = 32,
  parameter int BLOCK_BITS = 512
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_en,
  input  logic                  req_valid,
  input  logic [CMD_W-1:0]      req_cmd,
  input  logic [AW-1:0]         req_addr,
  input  logic [BLOCK_BITS-1:0] req_wdata,
  output logic                  busy,
  output logic                  done,
  output logic [BLOCK_BITS-1:0] rd_data,
  output logic                  ser_out,
  input  logic                  ser_in
);
  localparam int HDR_W = CMD_W + AW;
  localparam int CNT_W = $clog2(BLOCK_BITS);

  spe_phase_e phase;
  logic accept, hdr_shift, hdr_done, ack_seen, dat_shift, data_done;
  logic in_ack, in_rx;
  logic hdr_msb;
  logic [BLOCK_BITS-1:0] tx_aligned, dload, dq, rd_q;

  spe_ctrl #(
    .HDR_W(HDR_W), .WORD_BITS(WORD_BITS), .BLOCK_BITS(BLOCK_BITS), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .req_valid(req_valid),
    .req_cmd(req_cmd), .ser_in(ser_in), .phase(phase), .accept(accept),
    .hdr_shift(hdr_shift), .hdr_done(hdr_done), .ack_seen(ack_seen),
    .dat_shift(dat_shift), .data_done(data_done), .busy(busy), .done(done)
  );

  spe_hdr_shift #(.HDR_W(HDR_W)) u_hdr (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val({req_cmd, req_addr}),
    .shift(hdr_shift), .msb(hdr_msb)
  );

  generate
    if (BLOCK_BITS > WORD_BITS) begin : g_pad
      assign tx_aligned = spe_is_block(req_cmd) ? req_wdata
                        : {req_wdata[WORD_BITS-1:0], {(BLOCK_BITS-WORD_BITS){1'b0}}};
    end else begin : g_same
      assign tx_aligned = req_wdata;
    end
  endgenerate

  assign dload = spe_is_read(req_cmd) ? '0 : tx_aligned;

  spe_data_shift #(.DW(BLOCK_BITS)) u_data (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(dload),
    .shift(dat_shift), .sin(ser_in), .q(dq)
  );

  assign in_ack = (phase == PH_ACK);
  assign in_rx  = (phase == PH_RX);

  always_ff @(posedge clk) begin
    if (!rst_n)                 rd_q <= '0;
    else if (data_done && in_rx) rd_q <= {dq[BLOCK_BITS-2:0], ser_in};
  end

  always_comb begin
    unique case (phase)
      PH_HDR:  ser_out = hdr_msb;
      PH_TX:   ser_out = dq[BLOCK_BITS-1];
      default: ser_out = 1'b0;
    endcase
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/spe_checker.sv
module spe_checker #(
  parameter int DW = 512
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          busy,
  input logic          done,
  input logic          ser_out,
  input logic [DW-1:0] rd_data,
  input logic          accept,
  input logic          hdr_done,
  input logic          ack_seen,
  input logic          in_ack
);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_busy_on_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);
  assert_line_low_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |-> !ser_out);
  assert_wait_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack && !ack_seen) |=> busy);
  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_en) |=> $stable(ser_out));
  assert_hdr_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done |-> bit_en);
  assert_rd_only_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> done);
endmodule

bind serial_pkt_engine spe_checker #(.DW(BLOCK_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .busy(busy), .done(done),
  .ser_out(ser_out), .rd_data(rd_data), .accept(accept), .hdr_done(hdr_done),
  .ack_seen(ack_seen), .in_ack(in_ack)
);

// File: tb/tb_serial_pkt_engine.sv
`timescale 1ns/1ps
module tb_serial_pkt_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_cmd = 2'b00;
  logic [8:0] req_addr = '0;
  logic [511:0] req_wdata = '0;
  logic busy, done, ser_out;
  logic ser_in = 1'b0;
  logic [511:0] rd_data;

  int vectors = 0;
  int miscompares = 0;
  logic [511:0] last_rd = '0;
  logic [511:0] rx_q[$];
  bit finished = 0;

  always #5 clk = ~clk;

  serial_pkt_engine dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .req_valid(req_valid),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .ser_out(ser_out), .ser_in(ser_in)
  );

  task automatic check(input bit ok, input string tag, input logic [511:0] act,
                       input logic [511:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One serial tick, with random stall cycles before it; checks every clock.
  task automatic one_bit(input logic sin, input logic chk, input logic exp, input string tag);
    logic en;
    do begin
      @(negedge clk);
      en = ($urandom % 4) != 0;
      bit_en = en;
      ser_in = sin;
      #1;
      check(busy === 1'b1 && done === 1'b0, "R8 busy/done in transfer",
            {510'b0, busy, done}, 512'b10);
      if (chk) check(ser_out === exp, tag, {511'b0, ser_out}, {511'b0, exp});
    end while (!en);
  endtask

  function automatic logic [511:0] rand512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic run_txn(input logic [1:0] cmd, input logic [8:0] addr,
                         input logic [511:0] wd, input int delay, input bit hold_req);
    logic [10:0] hdr;
    logic [511:0] rxv, exp_rd;
    int n;
    bit rd;
    hdr = {cmd, addr};
    n = cmd[1] ? 32 : 512;
    rd = cmd[0];
    rxv = rx_q.pop_front();
    exp_rd = cmd[1] ? {480'b0, rxv[31:0]} : rxv;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_wdata = wd;
    bit_en = 1'b0; ser_in = 1'b0;
    @(posedge clk); #1;
    if (hold_req) begin
      req_cmd = ~cmd; req_addr = ~addr; req_wdata = ~wd;
    end else begin
      req_valid = 1'b0;
    end
    for (int i = 0; i < 11; i++)
      one_bit(1'b0, 1'b1, hdr[10-i], i < 2 ? "R3 code bit" : "R2 header bit");
    for (int d = 0; d < delay; d++) one_bit(1'b0, 1'b1, 1'b0, "R4 line low in wait");
    one_bit(1'b1, 1'b1, 1'b0, "R4 line low at ack");
    for (int i = 0; i < n; i++) begin
      if (rd) one_bit(cmd[1] ? rxv[31-i] : rxv[511-i], 1'b0, 1'b0, "R6");
      else    one_bit(1'b0, 1'b1, cmd[1] ? wd[31-i] : wd[511-i], "R5 write data bit");
    end
    @(negedge clk);
    bit_en = 1'b0; ser_in = 1'b0;
    #1;
    check(done === 1'b1 && busy === 1'b1, "R7 done pulse", {510'b0, busy, done}, 512'b11);
    if (rd) begin
      check(rd_data === exp_rd, "R6 read result", rd_data, exp_rd);
      last_rd = exp_rd;
    end else begin
      check(rd_data === last_rd, "R10 rd_data held over write", rd_data, last_rd);
    end
    req_valid = 1'b0;
    @(negedge clk); #1;
    check(done === 1'b0 && busy === 1'b0, "R7 done drops, R8 busy drops",
          {510'b0, busy, done}, 512'b0);
    if (hold_req) begin
      @(negedge clk); #1;
      check(busy === 1'b0 && ser_out === 1'b0, "R9 request ignored while busy",
            {510'b0, busy, ser_out}, 512'b0);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) rx_q.push_back(rand512());
    repeat (3) @(negedge clk);
    #1;
    check(busy === 1'b0 && done === 1'b0 && ser_out === 1'b0 && rd_data === '0,
          "R1 reset state", {509'b0, busy, done, ser_out}, 512'b0);
    rst_n = 1'b1;
    // word write: code 10, ack after short wait
    run_txn(2'b10, 9'h048, rand512(), 3, 1'b0);
    // word read: code 11, immediate ack
    run_txn(2'b11, 9'h1FF, '0, 0, 1'b0);
    // block write: code 00, address 0x7C0 -> 111110000
    run_txn(2'b00, 9'b111110000, rand512(), 5, 1'b0);
    // block read: code 01 with a long acknowledge wait
    run_txn(2'b01, 9'b111110000, '0, 400, 1'b0);
    // word read with request held high throughout (must be ignored)
    run_txn(2'b11, 9'h0A5, '0, 2, 1'b1);
    // word write after reads: rd_data must keep the last read value
    run_txn(2'b10, 9'h155, rand512(), 1, 1'b1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule